// File: doc/BRIEF.md
# Write-Through Snooping Invalidate Cache

This block is a small direct-mapped cache that sits between one processor and a shared system bus. Each line holds one data word, a tag and a valid bit. The processor issues one request at a time and holds it until the block acknowledges it. A read that hits is answered from the cache. A read that misses fetches the word over the bus and fills the line. Every processor write goes out to memory as a bus write. A write that hits also updates the cached word. A write that misses leaves the cache unchanged.

Because the caches are write-through, memory always holds the latest value. The only copies that can go stale are those in other caches. To guard against this, the block has a snoop port that sees every write placed on the bus, together with the identifier of the master that issued it. When another master writes an address that this cache holds in a valid line, that line is invalidated. The next processor read of that address then misses and collects the fresh value from memory. Bus writes that carry the block's own master identifier are ignored.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses. `cpu_ready` and `bus_req` are low until a request is accepted.
- R2: A read whose line is valid and whose tag matches is a hit. `cpu_ready` pulses one cycle after the accepting edge, `cpu_rdata` holds the cached word, and no bus transaction is issued.
- R3: A read miss raises `bus_req` with `bus_we` low and the request address. The transfer completes on the edge where `bus_gnt` and `bus_ack` are both high. On that edge the line is filled with `bus_rdata`, and `cpu_ready` pulses in the following cycle with that word.
- R4: Every write issues one bus write carrying the processor address and data, and is acknowledged like a read miss. A write hit also updates the cached word. A write miss allocates nothing: the line keeps its previous contents and its valid state.
- R5: A snooped write from another master to an address held in a valid line clears that line. A later read of the address misses and returns the value now in memory.
- R6: A snooped write whose source identifier equals the OWN_ID parameter leaves every line untouched.
- R7: If a snoop invalidation and a processor lookup reach the same line in the same cycle, the invalidation wins. The lookup is treated as a miss and goes to the bus.
- R8: If another master writes the address of an outstanding read miss before that read completes, the fetched word is still returned, but the line is left invalid.
- R9: While a bus transfer has not completed, `bus_req` stays high and `bus_addr`, `bus_we` and `bus_wdata` stay unchanged. Without `bus_gnt` the transfer never completes.
- R10: The line index is the low IDX_W address bits and the tag is the remaining high bits. Two addresses with the same index displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request strobe; accepted when the block is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transfer request, held until completion |
| bus_we | output | 1 | Bus transfer direction, 1 = write |
| bus_addr | output | ADDR_W | Bus transfer address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Bus granted to this master |
| bus_ack | input | 1 | Memory completes the transfer |
| bus_rdata | input | DATA_W | Memory read data |
| snp_wr | input | 1 | A write is present on the shared bus |
| snp_src | input | ID_W | Identifier of the master issuing that write |
| snp_addr | input | ADDR_W | Address of that write |

## Verification
Cycles are counted from the edge that accepts a request. A read hit shows `cpu_ready` one cycle after that edge. A miss or a write shows it one cycle after the edge on which grant and acknowledge coincide. With the bench's memory model at latency L, that is L+2 cycles after acceptance. The bench drives inputs and samples outputs on falling edges. It counts falling edges until `cpu_ready` appears and compares the count with the figure its own tag model predicts. It also counts completed bus transfers, to confirm that hits never reach the bus. Snoops meant to collide with a lookup, or to overlap an outstanding fill, are driven on a chosen falling edge, so the edge that samples them is known.

// File: rtl/swc_pkg.sv
package swc_pkg;

  // Controller phase: idle and looking up, or waiting on a bus transfer.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } swc_state_e;

endpackage

// File: rtl/swc_store.sv
// Tag, valid and data storage: one word per line, direct mapped.
module swc_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor lookup port
  input  logic [IDX_W-1:0]  cpu_idx,
  output logic              cpu_vld,
  output logic [TAG_W-1:0]  cpu_tag,
  output logic [DATA_W-1:0] cpu_data,
  // snoop lookup port
  input  logic [IDX_W-1:0]  snp_idx,
  output logic              snp_vld,
  output logic [TAG_W-1:0]  snp_tag,
  // fill after a read miss
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  // word update after a write hit
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [DATA_W-1:0] upd_data,
  // snoop invalidation
  input  logic              kill_en,
  input  logic [IDX_W-1:0]  kill_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign cpu_vld  = vld_q[cpu_idx];
  assign cpu_tag  = tag_q[cpu_idx];
  assign cpu_data = dat_q[cpu_idx];
  assign snp_vld  = vld_q[snp_idx];
  assign snp_tag  = tag_q[snp_idx];

  // Invalidation takes priority over a fill of the same line.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (kill_en && kill_idx == IDX_W'(i))
          vld_q[i] <= 1'b0;
        else if (fill_en && fill_idx == IDX_W'(i))
          vld_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_en && fill_idx == IDX_W'(i)) begin
          tag_q[i] <= fill_tag;
          dat_q[i] <= fill_data;
        end else if (upd_en && upd_idx == IDX_W'(i)) begin
          dat_q[i] <= upd_data;
        end
      end
    end
  end

  // R5: an invalidated line reads back invalid on the next cycle
  a_r5_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kill_en |=> !vld_q[$past(kill_idx)]);

  // R3: a fill that is not overridden leaves a valid line with the new tag
  a_r3_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(kill_en && kill_idx == fill_idx))
      |=> (vld_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));

endmodule

// File: rtl/swc_snoop.sv
// Watches bus writes from other masters and selects the line to invalidate.
module swc_snoop #(
  parameter int              ADDR_W = 8,
  parameter int              IDX_W  = 3,
  parameter int              ID_W   = 2,
  parameter logic [ID_W-1:0] OWN_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_wr,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  line_idx,
  input  logic              line_vld,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  output logic              kill_en,
  output logic [IDX_W-1:0]  kill_idx,
  output logic              foreign_wr,
  output logic [ADDR_W-1:0] foreign_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  assign foreign_wr   = snp_wr && (snp_src != OWN_ID);
  assign foreign_addr = snp_addr;
  assign line_idx     = idx_of(snp_addr);
  assign kill_idx     = idx_of(snp_addr);
  assign kill_en      = foreign_wr && line_vld && (line_tag == tag_of(snp_addr));

  // R6: writes carrying this master's own identifier never invalidate
  a_r6_own_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_wr && snp_src == OWN_ID) |-> !kill_en);

endmodule

// File: rtl/swc_ctrl.sv
// Request sequencing: lookup, bus transfer, fill or update, completion.
module swc_ctrl
  import swc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              look_vld,
  input  logic [ADDR_W-IDX_W-1:0] look_tag,
  input  logic [DATA_W-1:0] look_data,
  input  logic              kill_en,
  input  logic [IDX_W-1:0]  kill_idx,
  input  logic              foreign_wr,
  input  logic [ADDR_W-1:0] foreign_addr,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [ADDR_W-IDX_W-1:0] fill_tag,
  output logic [DATA_W-1:0] fill_data,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [DATA_W-1:0] upd_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  swc_state_e        state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_we_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic              live_q;      // the pending line may still be written into the cache
  logic              ready_q;
  logic [DATA_W-1:0] rdata_q;

  // named internal events
  logic accept, tag_hit, kill_same, lookup_hit, read_hit;
  logic xfer_done, snoop_pend, live_now;

  assign accept     = (state_q == ST_IDLE) && cpu_req;
  assign tag_hit    = look_vld && (look_tag == tag_of(cpu_addr));
  assign kill_same  = kill_en && (kill_idx == idx_of(cpu_addr));
  assign lookup_hit = tag_hit && !kill_same;
  assign read_hit   = accept && !cpu_we && lookup_hit;
  assign xfer_done  = (state_q == ST_BUS) && bus_gnt && bus_ack;
  assign snoop_pend = (state_q == ST_BUS) && foreign_wr && (foreign_addr == pend_addr_q);
  assign live_now   = live_q && !snoop_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      pend_addr_q  <= '0;
      pend_we_q    <= 1'b0;
      pend_wdata_q <= '0;
      live_q       <= 1'b0;
      ready_q      <= 1'b0;
      rdata_q      <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (read_hit) begin
            rdata_q <= look_data;
            ready_q <= 1'b1;
          end else if (accept) begin
            state_q      <= ST_BUS;
            pend_addr_q  <= cpu_addr;
            pend_we_q    <= cpu_we;
            pend_wdata_q <= cpu_wdata;
            live_q       <= cpu_we ? lookup_hit : 1'b1;
          end
        end
        ST_BUS: begin
          live_q <= live_now;
          if (xfer_done) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b1;
            if (!pend_we_q) rdata_q <= bus_rdata;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;

  assign bus_req   = (state_q == ST_BUS);
  assign bus_we    = pend_we_q;
  assign bus_addr  = pend_addr_q;
  assign bus_wdata = pend_wdata_q;

  assign fill_en   = xfer_done && !pend_we_q && live_now;
  assign fill_idx  = idx_of(pend_addr_q);
  assign fill_tag  = tag_of(pend_addr_q);
  assign fill_data = bus_rdata;
  assign upd_en    = xfer_done && pend_we_q && live_now;
  assign upd_idx   = idx_of(pend_addr_q);
  assign upd_data  = pend_wdata_q;

  // R2: a clean read hit completes next cycle without the bus
  a_r2_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_we && tag_hit && !kill_same) |=> (cpu_ready && !bus_req));

  // R7: a colliding invalidation turns the lookup into a bus read
  a_r7_kill_forces_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_we && kill_same) |=> (!cpu_ready && bus_req && !bus_we));

  // R4: every accepted write goes to the bus as a write
  a_r4_write_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_we) |=> (bus_req && bus_we && bus_addr == $past(cpu_addr)));

  // R9: an unfinished transfer holds its request and payload
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_gnt && bus_ack))
      |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

endmodule

// File: rtl/snoop_wt_cache.sv
// Direct-mapped write-through cache with bus-write snoop invalidation.
module snoop_wt_cache #(
  parameter int              ADDR_W = 8,
  parameter int              DATA_W = 16,
  parameter int              IDX_W  = 3,
  parameter int              ID_W   = 2,
  parameter logic [ID_W-1:0] OWN_ID = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_wr,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              look_vld;
  logic [TAG_W-1:0]  look_tag;
  logic [DATA_W-1:0] look_data;
  logic [IDX_W-1:0]  sn_idx;
  logic              sn_vld;
  logic [TAG_W-1:0]  sn_tag;
  logic              kill_en;
  logic [IDX_W-1:0]  kill_idx;
  logic              foreign_wr;
  logic [ADDR_W-1:0] foreign_addr;
  logic              fill_en, upd_en;
  logic [IDX_W-1:0]  fill_idx, upd_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [DATA_W-1:0] fill_data, upd_data;

  swc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_idx(cpu_addr[IDX_W-1:0]), .cpu_vld(look_vld), .cpu_tag(look_tag), .cpu_data(look_data),
    .snp_idx(sn_idx), .snp_vld(sn_vld), .snp_tag(sn_tag),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
    .kill_en(kill_en), .kill_idx(kill_idx)
  );

  swc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .OWN_ID(OWN_ID)) snoop_i (
    .clk(clk), .rst_n(rst_n),
    .snp_wr(snp_wr), .snp_src(snp_src), .snp_addr(snp_addr),
    .line_idx(sn_idx), .line_vld(sn_vld), .line_tag(sn_tag),
    .kill_en(kill_en), .kill_idx(kill_idx),
    .foreign_wr(foreign_wr), .foreign_addr(foreign_addr)
  );

  swc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .look_vld(look_vld), .look_tag(look_tag), .look_data(look_data),
    .kill_en(kill_en), .kill_idx(kill_idx),
    .foreign_wr(foreign_wr), .foreign_addr(foreign_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data)
  );

endmodule

// File: tb/snoop_wt_cache_tb_top.sv
module snoop_wt_cache_tb_top;
  localparam int              CLK_PERIOD = 10;
  localparam int              WDOG       = 150000;
  localparam logic [1:0]      OWN        = 2'd1;
  localparam logic [1:0]      OTHER      = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_gnt = 1'b1, bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic        snp_wr = 1'b0;
  logic [1:0]  snp_src = '0;
  logic [7:0]  snp_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_wt_cache #(.ADDR_W(8), .DATA_W(16), .IDX_W(3), .ID_W(2), .OWN_ID(OWN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .snp_wr(snp_wr), .snp_src(snp_src), .snp_addr(snp_addr)
  );

  // memory and cache model
  logic [15:0] mem [256];
  bit          mvld [8];
  logic [4:0]  mtag [8];
  int          lat = 1;
  int          txn_cnt = 0;
  int          n_chk = 0, n_bad = 0;

  function automatic logic [2:0] bidx(input logic [7:0] a); return a[2:0]; endfunction
  function automatic logic [4:0] btag(input logic [7:0] a); return a[7:3]; endfunction
  function automatic bit mhit(input logic [7:0] a);
    return mvld[bidx(a)] && (mtag[bidx(a)] == btag(a));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory responder: acknowledges lat cycles after seeing a granted request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        cnt = 0;
      end else if (bus_req && bus_gnt) begin
        if (cnt >= lat) begin
          bus_ack = 1'b1;
          txn_cnt++;
          if (bus_we) mem[bus_addr] = bus_wdata;
          else        bus_rdata = mem[bus_addr];
        end else begin
          cnt++;
        end
      end
    end
  end

  // present a bus write from some master; update memory and model for foreign ones
  task automatic drive_snoop(input logic [7:0] sa, input logic [1:0] ss, input logic [15:0] sd);
    snp_wr = 1'b1; snp_src = ss; snp_addr = sa;
    if (ss != OWN) begin
      mem[sa] = sd;
      if (mhit(sa)) mvld[bidx(sa)] = 1'b0;
    end
  endtask

  task automatic snoop_only(input logic [7:0] sa, input logic [1:0] ss, input logic [15:0] sd);
    @(negedge clk);
    drive_snoop(sa, ss, sd);
    @(negedge clk);
    snp_wr = 1'b0;
  endtask

  // one processor request; sk<0: no snoop, sk=0: snoop with the request, sk>0: k falling edges later
  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [15:0] wd,
                        input int sk, input logic [7:0] sa, input logic [1:0] ss,
                        input logic [15:0] sd);
    bit    exp_hit, poison;
    int    n, t0, exp_lat;
    string req;
    @(negedge clk);
    snp_wr = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (sk == 0) drive_snoop(sa, ss, sd);
    exp_hit = mhit(a);
    poison  = 1'b0;
    t0 = txn_cnt;
    exp_lat = (!we && exp_hit) ? 1 : lat + 2;
    req = we ? "R4" : (exp_hit ? "R2" : "R3");
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      cpu_req = 1'b0;
      snp_wr  = 1'b0;
      if (sk == n) begin
        drive_snoop(sa, ss, sd);
        if (ss != OWN && sa == a && !we) poison = 1'b1;
      end
      if (cpu_ready || n > lat + 40) break;
    end
    check(n == exp_lat, req, "completion latency", n, exp_lat);
    check((txn_cnt - t0) == ((!we && exp_hit) ? 0 : 1), req, "bus transfers",
          txn_cnt - t0, (!we && exp_hit) ? 0 : 1);
    if (!we) check(cpu_rdata == mem[a], req, "read data", int'(cpu_rdata), int'(mem[a]));
    else     check(mem[a] == wd, "R4", "memory after write", int'(mem[a]), int'(wd));
    if (!we && !exp_hit && !poison) begin
      mvld[bidx(a)] = 1'b1;
      mtag[bidx(a)] = btag(a);
    end
  endtask

  task automatic rd(input logic [7:0] a);
    cpu_op(1'b0, a, '0, -1, '0, '0, '0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cpu_op(1'b1, a, d, -1, '0, '0, '0);
  endtask

  // watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit          miss_seen;
    int          t0;
    logic [15:0] lfsr;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5a3c;
    for (int i = 0; i < 8; i++) begin mvld[i] = 1'b0; mtag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check(cpu_ready == 1'b0, "R1", "cpu_ready after reset", int'(cpu_ready), 0);
    check(bus_req == 1'b0,   "R1", "bus_req after reset",   int'(bus_req), 0);

    // R1/R3/R10: sweep every address; all miss, each tag displaces the last
    for (int a = 0; a < 256; a++) begin
      lat = a % 3;
      rd(8'(a));
    end
    lat = 1;
    for (int a = 248; a < 256; a++) rd(8'(a));     // R2: hits on the last tag
    for (int a = 0; a < 8; a++) rd(8'(a));         // R10: displaced, miss again

    // R4: write hit updates cache; write miss does not allocate
    wr(8'd2, 16'hbeef);
    rd(8'd2);
    wr(8'd11, 16'h1234);
    rd(8'd3);
    rd(8'd11);

    // R5: foreign writes invalidate every cached line
    for (int i = 0; i < 8; i++) begin
      snoop_only(8'(i), OTHER, 16'(16'h7000 + i));
      rd(8'(i));
    end

    // R6: own-source bus writes leave lines alone (read hits, one cycle)
    rd(8'd20);
    snoop_only(8'd20, OWN, 16'h0000);
    check(mhit(8'd20), "R6", "model still holds line", 0, 1);
    rd(8'd20);

    // R7: collision of invalidation and lookup -> miss with fresh word
    rd(8'd21);
    cpu_op(1'b0, 8'd21, '0, 0, 8'd21, OTHER, 16'hc0de);
    rd(8'd21);

    // R8: foreign write to the address of an outstanding fill
    lat = 4;
    cpu_op(1'b0, 8'd30, '0, 2, 8'd30, OTHER, 16'hfa11);
    check(!mhit(8'd30), "R8", "model keeps line invalid", 1, 0);
    rd(8'd30);   // must miss again
    lat = 1;

    // R9: no completion without grant; request held stable
    @(negedge clk);
    bus_gnt = 1'b0;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'd77;
    t0 = txn_cnt;
    @(negedge clk);
    cpu_req = 1'b0;
    miss_seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!bus_req || bus_addr != 8'd77 || cpu_ready) miss_seen = 1'b1;
      @(negedge clk);
    end
    check(!miss_seen, "R9", "request held while ungranted", int'(miss_seen), 0);
    check(txn_cnt == t0, "R9", "no transfer without grant", txn_cnt - t0, 0);
    bus_gnt = 1'b1;
    begin
      int n = 0;
      while (!cpu_ready && n < 50) begin @(negedge clk); n++; end
      check(cpu_ready && cpu_rdata == mem[77], "R9", "data after grant",
            int'(cpu_rdata), int'(mem[77]));
    end
    mvld[bidx(8'd77)] = 1'b1; mtag[bidx(8'd77)] = btag(8'd77);
    rd(8'd77);

    // mixed sequence over a small address set
    lfsr = 16'hace1;
    for (int k = 0; k < 300; k++) begin
      logic [7:0] a, sa;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a  = {3'b000, lfsr[11:10], lfsr[9:7]};
      sa = {3'b000, lfsr[15:14], lfsr[6:4]};
      lat = int'(lfsr[1:0]);
      case (lfsr[3:2])
        2'd0, 2'd1: rd(a);
        2'd2:       wr(a, lfsr ^ 16'h0f0f);
        default: begin
          snoop_only(sa, lfsr[12] ? OTHER : OWN, ~lfsr);
          rd(sa);
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule